// File: doc/BRIEF.md
# E1 Spare-Bit Multiframe Buffer

This block sits on the time slot 0 path of an E1 framer and handles the five national spare bits, Sa4 to Sa8, one CRC-4 multiframe at a time. Time slot 0 alternates between the frame alignment word (even frames) and the service word (odd frames). The spare bits ride in bits 4 to 8 of each service word, so a 16-frame multiframe carries eight values of each spare bit. The block keeps one 8-bit register per spare bit in each direction.

On receive, the block gathers the spare bits from the eight service words of a multiframe. When frame 0 of the next multiframe arrives, it publishes all five registers together and raises a sticky receive interrupt. On transmit, frame 0 copies the five host-written registers into shadow copies and raises a sticky transmit interrupt. The shadow bits are then placed into the service words of that multiframe.

If the host does not refresh the transmit registers, the same contents go out again in each following multiframe. When a transparent input is asserted, the time slot 0 byte passes through untouched. The upstream aligner supplies a frame number from 0 to 15 with each time slot 0 byte.

Top module: `e1_sa_mfbuf`

## Requirements
- R1: On a receive frame 0 strobe, the register for spare bit Sa(4+s) (host address s, s = 0..4) loads the values captured since the previous frame 0. Register bit i holds byte bit (4-s) of frame 2i+1, where byte bit 7 is the first bit on the line. Even frames and byte bits 7:5 are not captured. The new values are readable from the clock edge that takes the strobe.
- R2: The receive registers keep their value on every clock without a receive frame 0 strobe.
- R3: A receive frame 0 strobe sets the receive interrupt flag (irq_rx_mf_o, status bit 0 at address 15) at that clock edge.
- R4: On a transmit odd frame with transparent mode off, tx_ts0_o carries the input byte with byte bit (4-s) replaced by bit (frame>>1) of the Sa(4+s) shadow. The shadow is loaded from the host transmit registers (addresses 8+s, read back as written) at the latest transmit frame 0 strobe.
- R5: Host writes to the transmit registers between two frame 0 strobes do not change the bits sent in the current multiframe.
- R6: With no host write between two multiframes, the previous shadow contents are sent again.
- R7: While ts0_transp_i is 1, tx_ts0_o equals the input byte.
- R8: Even frames and byte bits 7:5 of odd frames pass to tx_ts0_o unchanged.
- R9: A transmit frame 0 strobe sets the transmit interrupt flag (irq_tx_mf_o, status bit 1) at that clock edge.
- R10: Writing 1 to a status bit at address 15 clears that flag, and writing 0 leaves it. A setting event in the same clock wins over the clear.
- R11: After reset, all registers, both flags and tx_valid_o are 0.
- R12: tx_valid_o repeats tx_valid_i one clock later, together with the processed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive time slot 0 byte strobe |
| rx_frame_i | input | 4 | Receive frame number within multiframe |
| rx_ts0_i | input | 8 | Receive time slot 0 byte, bit 7 first on line |
| tx_valid_i | input | 1 | Transmit time slot 0 byte strobe |
| tx_frame_i | input | 4 | Transmit frame number within multiframe |
| tx_ts0_i | input | 8 | Transmit time slot 0 byte before insertion |
| ts0_transp_i | input | 1 | Time slot 0 transparent mode, disables insertion |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 4 | Host register address |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data (combinational) |
| irq_rx_mf_o | output | 1 | Sticky receive multiframe begin flag |
| irq_tx_mf_o | output | 1 | Sticky transmit multiframe begin flag |
| tx_valid_o | output | 1 | Transmit byte strobe out |
| tx_ts0_o | output | 8 | Transmit time slot 0 byte after insertion |

## Verification
A wrong capture slot or bit lane in the receive accumulator stays hidden until the next frame 0 publishes it. It then shows at a host read of the wrong spare-bit register, up to one multiframe late. A shadow loaded at the wrong time, or overwritten by a mid-multiframe host write, shows in the next odd-frame byte on tx_ts0_o, one clock after its strobe. A missed repetition shows only in the multiframe after the skipped update. Flag faults are visible on the interrupt pins in the cycle after a frame 0 or a status write.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int SA_COUNT     = 5;
  localparam int SW_PER_MF    = 8;
  localparam int SA_FIRST_POS = 4;   // line position 1..8 of first spare bit
  localparam int ADDR_RX_BASE = 0;
  localparam int ADDR_TX_BASE = 8;
  localparam int ADDR_STATUS  = 15;

  // byte lane of spare bit s; line position 1 is byte bit 7
  function automatic int sa_lane(input int s);
    return 8 - (SA_FIRST_POS + s);
  endfunction
endpackage

// File: rtl/e1_sa_rx_capture.sv
module e1_sa_rx_capture
  import e1_sa_pkg::*;
#(
  parameter int N_SA = SA_COUNT,
  parameter int N_SW = SW_PER_MF,
  localparam int FW  = $clog2(2 * N_SW),
  localparam int SWW = $clog2(N_SW)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [FW-1:0]              frame_i,
  input  logic [7:0]                 ts0_i,
  output logic [N_SA-1:0][N_SW-1:0]  rx_sa_o,
  output logic                       mf_begin_o
);
  logic [N_SA-1:0][N_SW-1:0] acc_q, pub_q;
  logic [SWW-1:0]            sw_idx;
  logic                      is_sw;

  assign sw_idx     = frame_i[FW-1:1];
  assign is_sw      = valid_i && frame_i[0];
  assign mf_begin_o = valid_i && (frame_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
    end else if (is_sw) begin
      for (int s = 0; s < N_SA; s++) acc_q[s][sw_idx] <= ts0_i[sa_lane(s)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pub_q <= '0;
    else if (mf_begin_o) pub_q <= acc_q;
  end

  assign rx_sa_o = pub_q;
endmodule

// File: rtl/e1_sa_tx_insert.sv
module e1_sa_tx_insert
  import e1_sa_pkg::*;
#(
  parameter int N_SA = SA_COUNT,
  parameter int N_SW = SW_PER_MF,
  localparam int FW  = $clog2(2 * N_SW),
  localparam int SWW = $clog2(N_SW)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [FW-1:0]              frame_i,
  input  logic [7:0]                 ts0_i,
  input  logic                       transp_i,
  input  logic [N_SA-1:0][N_SW-1:0]  host_tx_i,
  output logic [N_SA-1:0][N_SW-1:0]  shadow_o,
  output logic                       mf_begin_o,
  output logic                       valid_o,
  output logic [7:0]                 ts0_o
);
  logic [N_SA-1:0][N_SW-1:0] shadow_q;
  logic [SWW-1:0]            sw_idx;
  logic [7:0]                ins_byte;
  logic                      valid_q;
  logic [7:0]                ts0_q;

  assign sw_idx     = frame_i[FW-1:1];
  assign mf_begin_o = valid_i && (frame_i == '0);

  always_comb begin
    ins_byte = ts0_i;
    if (frame_i[0] && !transp_i) begin
      for (int s = 0; s < N_SA; s++) ins_byte[sa_lane(s)] = shadow_q[s][sw_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         shadow_q <= '0;
    else if (mf_begin_o) shadow_q <= host_tx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ts0_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) ts0_q <= ins_byte;
    end
  end

  assign shadow_o = shadow_q;
  assign valid_o  = valid_q;
  assign ts0_o    = ts0_q;
endmodule

// File: rtl/e1_sa_host_regs.sv
module e1_sa_host_regs
  import e1_sa_pkg::*;
#(
  parameter int N_SA   = SA_COUNT,
  parameter int N_SW   = SW_PER_MF,
  parameter int ADDR_W = 4,
  parameter int DW     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  input  logic [N_SA-1:0][N_SW-1:0]  rx_sa_i,
  input  logic                       rx_begin_i,
  input  logic                       tx_begin_i,
  output logic [N_SA-1:0][N_SW-1:0]  tx_sa_o,
  output logic                       irq_rx_o,
  output logic                       irq_tx_o
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(ADDR_STATUS);

  logic stat_wr;
  logic rx_flag_q, tx_flag_q;

  assign stat_wr = we_i && (addr_i == STAT_A);

  for (genvar g = 0; g < N_SA; g++) begin : g_tx
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(ADDR_TX_BASE + g);
    logic [N_SW-1:0] reg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      reg_q <= '0;
      else if (we_i && addr_i == MY_A)  reg_q <= wdata_i[N_SW-1:0];
    end
    assign tx_sa_o[g] = reg_q;
  end

  // set beats write-one-to-clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_flag_q <= 1'b0;
      tx_flag_q <= 1'b0;
    end else begin
      if (rx_begin_i)                  rx_flag_q <= 1'b1;
      else if (stat_wr && wdata_i[0])  rx_flag_q <= 1'b0;
      if (tx_begin_i)                  tx_flag_q <= 1'b1;
      else if (stat_wr && wdata_i[1])  tx_flag_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < N_SA; s++) begin
      if (addr_i == ADDR_W'(ADDR_RX_BASE + s)) rdata_o = DW'(rx_sa_i[s]);
      if (addr_i == ADDR_W'(ADDR_TX_BASE + s)) rdata_o = DW'(tx_sa_o[s]);
    end
    if (addr_i == STAT_A) rdata_o = DW'({tx_flag_q, rx_flag_q});
  end

  assign irq_rx_o = rx_flag_q;
  assign irq_tx_o = tx_flag_q;
endmodule

// File: rtl/e1_sa_mfbuf.sv
module e1_sa_mfbuf
  import e1_sa_pkg::*;
#(
  parameter int N_SA   = SA_COUNT,
  parameter int N_SW   = SW_PER_MF,
  parameter int ADDR_W = 4,
  parameter int DW     = 8,
  localparam int FW    = $clog2(2 * N_SW)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [FW-1:0]     rx_frame_i,
  input  logic [7:0]        rx_ts0_i,
  input  logic              tx_valid_i,
  input  logic [FW-1:0]     tx_frame_i,
  input  logic [7:0]        tx_ts0_i,
  input  logic              ts0_transp_i,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DW-1:0]     host_wdata_i,
  output logic [DW-1:0]     host_rdata_o,
  output logic              irq_rx_mf_o,
  output logic              irq_tx_mf_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_ts0_o
);
  logic [N_SA-1:0][N_SW-1:0] rx_sa, tx_host, tx_shadow;
  logic                      rx_begin, tx_begin;

  e1_sa_rx_capture #(.N_SA(N_SA), .N_SW(N_SW)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (rx_valid_i),
    .frame_i    (rx_frame_i),
    .ts0_i      (rx_ts0_i),
    .rx_sa_o    (rx_sa),
    .mf_begin_o (rx_begin)
  );

  e1_sa_tx_insert #(.N_SA(N_SA), .N_SW(N_SW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (tx_valid_i),
    .frame_i    (tx_frame_i),
    .ts0_i      (tx_ts0_i),
    .transp_i   (ts0_transp_i),
    .host_tx_i  (tx_host),
    .shadow_o   (tx_shadow),
    .mf_begin_o (tx_begin),
    .valid_o    (tx_valid_o),
    .ts0_o      (tx_ts0_o)
  );

  e1_sa_host_regs #(.N_SA(N_SA), .N_SW(N_SW), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (host_we_i),
    .addr_i     (host_addr_i),
    .wdata_i    (host_wdata_i),
    .rdata_o    (host_rdata_o),
    .rx_sa_i    (rx_sa),
    .rx_begin_i (rx_begin),
    .tx_begin_i (tx_begin),
    .tx_sa_o    (tx_host),
    .irq_rx_o   (irq_rx_mf_o),
    .irq_tx_o   (irq_tx_mf_o)
  );
endmodule

// File: rtl/e1_sa_mfbuf_chk.sv
module e1_sa_mfbuf_chk #(
  parameter int N_SA   = 5,
  parameter int N_SW   = 8,
  parameter int ADDR_W = 4,
  parameter int DW     = 8,
  parameter int FW     = 4
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      rx_valid_i,
  input logic [FW-1:0]             rx_frame_i,
  input logic                      tx_valid_i,
  input logic [FW-1:0]             tx_frame_i,
  input logic [7:0]                tx_ts0_i,
  input logic                      ts0_transp_i,
  input logic                      host_we_i,
  input logic [ADDR_W-1:0]         host_addr_i,
  input logic [DW-1:0]             host_wdata_i,
  input logic                      irq_rx_mf_o,
  input logic                      irq_tx_mf_o,
  input logic                      tx_valid_o,
  input logic [7:0]                tx_ts0_o,
  input logic [N_SA-1:0][N_SW-1:0] rx_sa,
  input logic [N_SA-1:0][N_SW-1:0] tx_shadow
);
  logic rx_b, tx_b, stat_wr;
  assign rx_b    = rx_valid_i && (rx_frame_i == '0);
  assign tx_b    = tx_valid_i && (tx_frame_i == '0);
  assign stat_wr = host_we_i && (host_addr_i == {ADDR_W{1'b1}});

  p_rx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_b |=> $stable(rx_sa));
  p_rx_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_b |=> irq_rx_mf_o);
  p_tx_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_b |=> irq_tx_mf_o);
  p_shadow_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_b |=> $stable(tx_shadow));
  p_transp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && ts0_transp_i |=> tx_ts0_o == $past(tx_ts0_i));
  p_even_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && !tx_frame_i[0] |=> tx_ts0_o == $past(tx_ts0_i));
  p_upper_pass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i |=> tx_ts0_o[7:5] == $past(tx_ts0_i[7:5]));
  p_w1c_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr && host_wdata_i[0] && !rx_b |=> !irq_rx_mf_o);
  p_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> tx_valid_o == $past(tx_valid_i));
endmodule

bind e1_sa_mfbuf e1_sa_mfbuf_chk #(
  .N_SA(N_SA), .N_SW(N_SW), .ADDR_W(ADDR_W), .DW(DW), .FW(FW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rx_valid_i   (rx_valid_i),
  .rx_frame_i   (rx_frame_i),
  .tx_valid_i   (tx_valid_i),
  .tx_frame_i   (tx_frame_i),
  .tx_ts0_i     (tx_ts0_i),
  .ts0_transp_i (ts0_transp_i),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .irq_rx_mf_o  (irq_rx_mf_o),
  .irq_tx_mf_o  (irq_tx_mf_o),
  .tx_valid_o   (tx_valid_o),
  .tx_ts0_o     (tx_ts0_o),
  .rx_sa        (rx_sa),
  .tx_shadow    (tx_shadow)
);

// File: tb/sim_e1_sa_mfbuf.sv
module sim_e1_sa_mfbuf;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, tx_valid = 1'b0, transp = 1'b0, we = 1'b0;
  logic [3:0] rx_frame = '0, tx_frame = '0, addr = '0;
  logic [7:0] rx_ts0 = '0, tx_ts0 = '0, wdata = '0;
  logic [7:0] rdata, tx_ts0_o;
  logic       irq_rx, irq_tx, tx_valid_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] host_m [5];
  logic [7:0] shadow_m [5];

  always #(CLK_PERIOD/2) clk = ~clk;

  e1_sa_mfbuf u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_valid_i(rx_valid), .rx_frame_i(rx_frame), .rx_ts0_i(rx_ts0),
    .tx_valid_i(tx_valid), .tx_frame_i(tx_frame), .tx_ts0_i(tx_ts0),
    .ts0_transp_i(transp),
    .host_we_i(we), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .irq_rx_mf_o(irq_rx), .irq_tx_mf_o(irq_tx),
    .tx_valid_o(tx_valid_o), .tx_ts0_o(tx_ts0_o)
  );

  function automatic logic [7:0] rpat(input int m, input int s);
    return 8'((m * 91 + s * 45 + 19) ^ (m << 5));
  endfunction
  function automatic logic [7:0] tpat(input int m, input int s);
    return 8'(m * 77 + s * 23 + 140);
  endfunction

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    if (a >= 8 && a <= 12) host_m[a - 8] = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(rdata === exp, req, rdata, exp);
  endtask

  task automatic send_frame(input int m, input int f, input logic tr);
    logic [7:0] rb, tb, exp;
    string tag;
    rb = 8'(f * 29 + m * 7);
    if (f % 2 == 1) begin
      rb[7:5] = 3'(f * 3 + m);
      for (int s = 0; s < 5; s++) rb[4 - s] = rpat(m, s)[f / 2];
    end
    tb = 8'(f * 53 + m * 11 + 3);
    @(negedge clk);
    rx_valid = 1'b1; rx_frame = 4'(f); rx_ts0 = rb;
    tx_valid = 1'b1; tx_frame = 4'(f); tx_ts0 = tb; transp = tr;
    if (f == 0) for (int s = 0; s < 5; s++) shadow_m[s] = host_m[s];
    exp = tb;
    if ((f % 2 == 1) && !tr) for (int s = 0; s < 5; s++) exp[4 - s] = shadow_m[s][f / 2];
    if (tr)              tag = "R7";
    else if (f % 2 == 0) tag = "R8";
    else if (m == 3)     tag = "R6";
    else if (m == 1 && f > 7) tag = "R5";
    else                 tag = "R4";
    @(negedge clk);
    rx_valid = 1'b0; tx_valid = 1'b0;
    chk(tx_valid_o === 1'b1, "R12", {7'd0, tx_valid_o}, 8'd1);
    chk(tx_ts0_o === exp, tag, tx_ts0_o, exp);
    @(negedge clk);
    chk(tx_valid_o === 1'b0, "R12", {7'd0, tx_valid_o}, 8'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < 5; s++) begin host_m[s] = '0; shadow_m[s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    for (int s = 0; s < 5; s++) begin
      rd_chk(4'(s), 8'h00, "R11 rx reg");
      rd_chk(4'(8 + s), 8'h00, "R11 tx reg");
    end
    rd_chk(4'd15, 8'h00, "R11 status");
    chk(irq_rx === 1'b0 && irq_tx === 1'b0, "R11 irq", {6'd0, irq_tx, irq_rx}, 8'd0);
    chk(tx_valid_o === 1'b0, "R11 tx_valid_o", {7'd0, tx_valid_o}, 8'd0);

    for (int m = 0; m < 6; m++) begin
      if (m != 3) for (int s = 0; s < 5; s++) hw(4'(8 + s), tpat(m, s));
      for (int s = 0; s < 5; s++) rd_chk(4'(8 + s), host_m[s], "R4 tx readback");
      send_frame(m, 0, m == 4);
      chk(irq_rx === 1'b1, "R3", {7'd0, irq_rx}, 8'd1);
      chk(irq_tx === 1'b1, "R9", {7'd0, irq_tx}, 8'd1);
      for (int s = 0; s < 5; s++)
        rd_chk(4'(s), (m == 0) ? 8'h00 : rpat(m - 1, s), "R1");
      if (m == 0) rd_chk(4'd15, 8'h03, "R3 R9 status");
      if (m == 1) begin
        hw(4'd15, 8'h00);
        rd_chk(4'd15, 8'h03, "R10 write zero");
        hw(4'd15, 8'h01);
        rd_chk(4'd15, 8'h02, "R10 clear rx only");
      end
      hw(4'd15, 8'h03);
      chk(irq_rx === 1'b0 && irq_tx === 1'b0, "R10", {6'd0, irq_tx, irq_rx}, 8'd0);
      for (int f = 1; f < 16; f++) begin
        send_frame(m, f, m == 4);
        if (m == 1 && f == 7) for (int s = 0; s < 5; s++) hw(4'(8 + s), 8'hA5 ^ 8'(s * 17));
        if (f == 8) for (int s = 0; s < 5; s++)
          rd_chk(4'(s), (m == 0) ? 8'h00 : rpat(m - 1, s), "R2");
      end
    end

    // R10 set beats clear in same cycle
    @(negedge clk);
    rx_valid = 1'b1; rx_frame = 4'd0; rx_ts0 = 8'h00;
    we = 1'b1; addr = 4'd15; wdata = 8'h01;
    @(negedge clk);
    rx_valid = 1'b0; we = 1'b0;
    chk(irq_rx === 1'b1, "R10 set wins", {7'd0, irq_rx}, 8'd1);
    rd_chk(4'd0, rpat(5, 0), "R1 final");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule